// File: doc/BRIEF.md
# Pre-adder and Multiplier Operand Stage

This block is the operand front end of a signed multiply datapath. It takes a 30-bit A operand, an 18-bit B operand and a 27-bit D operand. A and B each pass through a pair of cascaded registers. D passes through an optional register. A 27-bit pre-adder combines D with a second operand, and a signed 27 x 18 multiplier follows it. The product is held in an optional pipeline register and an optional output register, and it is sign-extended to 48 bits.

A 5-bit run-time mode word picks the tap of each register pair. It can also force either pre-adder input to zero and choose between addition and subtraction. Static parameters set the rest of the datapath. One picks whether A or B is the second pre-adder operand. Two others pick whether each multiplier port takes the pre-adder result or the raw operand. When both ports take the pre-adder result, the block computes the square of the pre-adder result. Every register has a synchronous active-high reset and a clock enable, and the reset takes priority over the enable.

Top module: `preadd_mult_front`

## Requirements
- R1: Every register clears to zero on its own synchronous active-high reset, even when its clock enable is high. With all resets asserted, `prod`, `mul_a_op` and `mul_b_op` read zero.
- R2: Each of the four A/B registers loads only on a clock edge where its own enable is high, and otherwise keeps its value.
- R3: Mode bit 0 selects the A tap (1 = first register, 0 = second register). Mode bit 4 selects the B tap with the same encoding.
- R4: Pre-adder result = Dterm + Oterm when mode bit 3 is 0, and Dterm - Oterm when mode bit 3 is 1. Dterm is the registered D when mode bit 2 is 1 and zero otherwise. Oterm is zero when mode bit 1 is 1. The result wraps to 27 bits, two's complement.
- R5: When PRE_FROM_B = 0, the pre-adder's second operand is bits 26:0 of the A tap, read as signed. Bits 29:27 of A never affect any output. When PRE_FROM_B = 1, the second operand is the B tap, sign-extended to 27 bits.
- R6: `mul_a_op` is the pre-adder result when MA_FROM_PRE = 1, and A tap bits 26:0 otherwise. `mul_b_op` is bits 17:0 of the pre-adder result when MB_FROM_PRE = 1, and the B tap otherwise. With both parameters set to 1, the product is the pre-adder result times itself whenever that result lies in the signed 18-bit range.
- R7: `prod` is the signed 45-bit product of `mul_a_op` and `mul_b_op`, sign-extended to 48 bits.
- R8: With the first-register taps, AD_REG = 0 and M_REG = P_REG = 1, a change on `a_in` appears on `prod` after exactly three rising edges.
- R9: With `ce_p` low, `prod` holds its value whatever the inputs do.
- R10: When AD_REG = 1, the pre-adder result is held in its own register, gated by `ce_ad` and cleared by `rst_ad`. While `ce_ad` is low, changes on D do not reach the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on rising edge |
| rst_a | input | 1 | Synchronous reset of both A registers |
| rst_b | input | 1 | Synchronous reset of both B registers |
| rst_d | input | 1 | Synchronous reset of the D register |
| rst_ad | input | 1 | Synchronous reset of the pre-adder result register |
| rst_m | input | 1 | Synchronous reset of the product pipeline register |
| rst_p | input | 1 | Synchronous reset of the output register |
| ce_a1 | input | 1 | Enable, first A register |
| ce_a2 | input | 1 | Enable, second A register |
| ce_b1 | input | 1 | Enable, first B register |
| ce_b2 | input | 1 | Enable, second B register |
| ce_d | input | 1 | Enable, D register |
| ce_ad | input | 1 | Enable, pre-adder result register |
| ce_m | input | 1 | Enable, product pipeline register |
| ce_p | input | 1 | Enable, output register |
| mode | input | 5 | Run-time mode word (taps, gates, add/subtract) |
| a_in | input | 30 | A operand |
| b_in | input | 18 | B operand |
| d_in | input | 27 | D operand |
| mul_a_op | output | 27 | Multiplier port A operand |
| mul_b_op | output | 18 | Multiplier port B operand |
| prod | output | 48 | Registered product, sign-extended |

## Verification
In the default configuration, a new A value reaches `prod` on the third rising edge: the first A register, then the pipeline register, then the output register. The bench samples one edge earlier and expects the old value, then samples on the third edge and expects the new one. In the mode sweep, the inputs are held for six edges before the falling-edge sample. Six edges covers the deepest path in either instance: the second-tap registers plus the pre-adder register in the squaring instance. The tap and enable checks freeze a register, move the input and wait long enough that the result can only come from the frozen value. The bench then releases the register and checks that the new value arrives.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
  localparam int MODE_W = 5;

  // bit 4 .. bit 0
  typedef struct packed {
    logic tap_b_first;
    logic sub;
    logic d_on;
    logic opnd_off;
    logic tap_a_first;
  } mode_t;
endpackage

// File: rtl/pmf_reg2.sv
module pmf_reg2 #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce1,
  input  logic         ce2,
  input  logic         tap_first,
  input  logic [W-1:0] din,
  output logic [W-1:0] q1,
  output logic [W-1:0] q2,
  output logic [W-1:0] tap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q1 <= '0;
    end else if (ce1) begin
      q1 <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q2 <= '0;
    end else if (ce2) begin
      q2 <= q1;
    end
  end

  assign tap = tap_first ? q1 : q2;
endmodule

// File: rtl/pmf_optreg.sv
module pmf_optreg #(
  parameter int W  = 27,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) begin
          r <= '0;
        end else if (ce) begin
          r <= d;
        end
      end
      assign q = r;
    end else begin : g_pass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/pmf_preadd.sv
module pmf_preadd #(
  parameter int W = 27
) (
  input  logic [W-1:0] d_val,
  input  logic [W-1:0] o_val,
  input  logic         d_on,
  input  logic         o_off,
  input  logic         sub,
  output logic [W-1:0] sum
);
  function automatic logic [W-1:0] preadd_f(
    input logic [W-1:0] dv, input logic [W-1:0] ov,
    input logic don, input logic ooff, input logic sb);
    logic [W-1:0] dt;
    logic [W-1:0] ot;
    dt = don ? dv : '0;
    ot = ooff ? '0 : ov;
    return sb ? (dt - ot) : (dt + ot);
  endfunction

  assign sum = preadd_f(d_val, o_val, d_on, o_off, sub);
endmodule

// File: rtl/pmf_mult.sv
module pmf_mult #(
  parameter int AW = 27,
  parameter int BW = 18,
  localparam int PW = AW + BW
) (
  input  logic [AW-1:0] x,
  input  logic [BW-1:0] y,
  output logic [PW-1:0] p
);
  function automatic logic [PW-1:0] smul_f(input logic [AW-1:0] xa, input logic [BW-1:0] yb);
    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] ye;
    xe = PW'($signed(xa));
    ye = PW'($signed(yb));
    return xe * ye;
  endfunction

  assign p = smul_f(x, y);
endmodule

// File: rtl/preadd_mult_front.sv
module preadd_mult_front #(
  parameter int A_W         = 30,
  parameter int B_W         = 18,
  parameter int D_W         = 27,
  parameter int P_W         = 48,
  parameter bit PRE_FROM_B  = 1'b0,
  parameter bit MA_FROM_PRE = 1'b1,
  parameter bit MB_FROM_PRE = 1'b0,
  parameter bit D_REG       = 1'b1,
  parameter bit AD_REG      = 1'b0,
  parameter bit M_REG       = 1'b1,
  parameter bit P_REG       = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_a,
  input  logic                      rst_b,
  input  logic                      rst_d,
  input  logic                      rst_ad,
  input  logic                      rst_m,
  input  logic                      rst_p,
  input  logic                      ce_a1,
  input  logic                      ce_a2,
  input  logic                      ce_b1,
  input  logic                      ce_b2,
  input  logic                      ce_d,
  input  logic                      ce_ad,
  input  logic                      ce_m,
  input  logic                      ce_p,
  input  logic [pmf_pkg::MODE_W-1:0] mode,
  input  logic [A_W-1:0]            a_in,
  input  logic [B_W-1:0]            b_in,
  input  logic [D_W-1:0]            d_in,
  output logic [D_W-1:0]            mul_a_op,
  output logic [B_W-1:0]            mul_b_op,
  output logic [P_W-1:0]            prod
);
  import pmf_pkg::*;

  localparam int PROD_W = D_W + B_W;
  localparam int EXT_W  = P_W - PROD_W;
  localparam int BEXT_W = D_W - B_W;

  mode_t md;
  assign md = mode_t'(mode);

  // named internal events for the checker
  logic [A_W-1:0]    a1_q, a2_q, a_sel;
  logic [B_W-1:0]    b1_q, b2_q, b_sel;
  logic [D_W-1:0]    d_q;
  logic [D_W-1:0]    a_low;
  logic [D_W-1:0]    b_ext;
  logic [D_W-1:0]    pre_opnd;
  logic [D_W-1:0]    ad_comb, ad_q;
  logic [PROD_W-1:0] prod_comb, m_q;
  logic [P_W-1:0]    prod_ext;

  pmf_reg2 #(.W(A_W)) u_a_pair (
    .clk(clk), .rst(rst_a), .ce1(ce_a1), .ce2(ce_a2),
    .tap_first(md.tap_a_first), .din(a_in),
    .q1(a1_q), .q2(a2_q), .tap(a_sel)
  );

  pmf_reg2 #(.W(B_W)) u_b_pair (
    .clk(clk), .rst(rst_b), .ce1(ce_b1), .ce2(ce_b2),
    .tap_first(md.tap_b_first), .din(b_in),
    .q1(b1_q), .q2(b2_q), .tap(b_sel)
  );

  pmf_optreg #(.W(D_W), .EN(D_REG)) u_d_reg (
    .clk(clk), .rst(rst_d), .ce(ce_d), .d(d_in), .q(d_q)
  );

  assign a_low = a_sel[D_W-1:0];
  assign b_ext = {{BEXT_W{b_sel[B_W-1]}}, b_sel};

  generate
    if (PRE_FROM_B) begin : g_pre_b
      assign pre_opnd = b_ext;
    end else begin : g_pre_a
      assign pre_opnd = a_low;
    end
  endgenerate

  pmf_preadd #(.W(D_W)) u_preadd (
    .d_val(d_q), .o_val(pre_opnd), .d_on(md.d_on),
    .o_off(md.opnd_off), .sub(md.sub), .sum(ad_comb)
  );

  pmf_optreg #(.W(D_W), .EN(AD_REG)) u_ad_reg (
    .clk(clk), .rst(rst_ad), .ce(ce_ad), .d(ad_comb), .q(ad_q)
  );

  generate
    if (MA_FROM_PRE) begin : g_ma_pre
      assign mul_a_op = ad_q;
    end else begin : g_ma_raw
      assign mul_a_op = a_low;
    end
    if (MB_FROM_PRE) begin : g_mb_pre
      assign mul_b_op = ad_q[B_W-1:0];
    end else begin : g_mb_raw
      assign mul_b_op = b_sel;
    end
  endgenerate

  pmf_mult #(.AW(D_W), .BW(B_W)) u_mult (
    .x(mul_a_op), .y(mul_b_op), .p(prod_comb)
  );

  pmf_optreg #(.W(PROD_W), .EN(M_REG)) u_m_reg (
    .clk(clk), .rst(rst_m), .ce(ce_m), .d(prod_comb), .q(m_q)
  );

  assign prod_ext = {{EXT_W{m_q[PROD_W-1]}}, m_q};

  pmf_optreg #(.W(P_W), .EN(P_REG)) u_p_reg (
    .clk(clk), .rst(rst_p), .ce(ce_p), .d(prod_ext), .q(prod)
  );
endmodule

// File: rtl/pmf_checker.sv
module pmf_checker #(
  parameter int A_W    = 30,
  parameter int B_W    = 18,
  parameter int D_W    = 27,
  parameter int P_W    = 48,
  parameter bit AD_REG = 1'b0,
  parameter bit M_REG  = 1'b1,
  parameter bit P_REG  = 1'b1,
  localparam int PROD_W = D_W + B_W,
  localparam int TOP_W  = P_W - PROD_W + 1
) (
  input logic              clk,
  input logic              rst_a,
  input logic              rst_b,
  input logic              rst_d,
  input logic              rst_ad,
  input logic              rst_m,
  input logic              rst_p,
  input logic              ce_a1,
  input logic              ce_b2,
  input logic              ce_ad,
  input logic              ce_m,
  input logic              ce_p,
  input logic [A_W-1:0]    a_in,
  input logic [A_W-1:0]    a1_q,
  input logic [A_W-1:0]    a2_q,
  input logic [A_W-1:0]    a_sel,
  input logic [B_W-1:0]    b2_q,
  input logic [D_W-1:0]    ad_q,
  input logic [PROD_W-1:0] m_q,
  input logic [P_W-1:0]    prod
);
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (rst_a && rst_b && rst_d && rst_ad && rst_m && rst_p) begin
      armed <= 1'b1;
    end
  end

  // R2: first A register captures its input when enabled
  a_r2_a1_load: assert property (@(posedge clk) disable iff (!armed)
    (ce_a1 && !rst_a) |=> (a1_q == $past(a_in)));

  // R2: second B register keeps its value when disabled
  a_r2_b2_hold: assert property (@(posedge clk) disable iff (!armed)
    (!ce_b2 && !rst_b) |=> $stable(b2_q));

  // R1: A reset wins over the enables
  a_r1_a_reset: assert property (@(posedge clk) disable iff (!armed)
    rst_a |=> (a1_q == '0 && a2_q == '0 && a_sel == '0));

  // R7: bits above the 45-bit product replicate its sign
  a_r7_sign_ext: assert property (@(posedge clk) disable iff (!armed)
    ($countones(prod[P_W-1:PROD_W-1]) == 0) || ($countones(prod[P_W-1:PROD_W-1]) == TOP_W));

  generate
    if (P_REG) begin : g_p_chk
      // R1: output reset wins over ce_p
      a_r1_p_reset: assert property (@(posedge clk) disable iff (!armed)
        rst_p |=> (prod == '0));
      // R9: disabled output register holds
      a_r9_p_hold: assert property (@(posedge clk) disable iff (!armed)
        (!ce_p && !rst_p) |=> $stable(prod));
    end
    if (M_REG && P_REG) begin : g_mp_chk
      // R7: output register takes the extended pipeline product
      a_r7_p_follows_m: assert property (@(posedge clk) disable iff (!armed)
        (ce_p && !rst_p) |=> (prod[PROD_W-1:0] == $past(m_q)));
      // R1: pipeline reset clears it
      a_r1_m_reset: assert property (@(posedge clk) disable iff (!armed)
        (rst_m && ce_m) |=> (m_q == '0));
    end
    if (AD_REG) begin : g_ad_chk
      // R10: pre-adder register holds when disabled
      a_r10_ad_hold: assert property (@(posedge clk) disable iff (!armed)
        (!ce_ad && !rst_ad) |=> $stable(ad_q));
    end
  endgenerate
endmodule

bind preadd_mult_front pmf_checker #(
  .A_W(A_W), .B_W(B_W), .D_W(D_W), .P_W(P_W),
  .AD_REG(AD_REG), .M_REG(M_REG), .P_REG(P_REG)
) u_pmf_checker (
  .clk(clk), .rst_a(rst_a), .rst_b(rst_b), .rst_d(rst_d),
  .rst_ad(rst_ad), .rst_m(rst_m), .rst_p(rst_p),
  .ce_a1(ce_a1), .ce_b2(ce_b2), .ce_ad(ce_ad), .ce_m(ce_m), .ce_p(ce_p),
  .a_in(a_in), .a1_q(a1_q), .a2_q(a2_q), .a_sel(a_sel),
  .b2_q(b2_q), .ad_q(ad_q), .m_q(m_q), .prod(prod)
);

// File: tb/test_preadd_mult_front.sv
`timescale 1ns/1ps
module test_preadd_mult_front;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_a, rst_b, rst_d, rst_ad, rst_m, rst_p;
  logic ce_a1, ce_a2, ce_b1, ce_b2, ce_d, ce_ad, ce_m, ce_p;
  logic [4:0]  mode;
  logic [29:0] a_in;
  logic [17:0] b_in;
  logic [26:0] d_in;
  logic [26:0] mul_a_op, sq_mul_a_op;
  logic [17:0] mul_b_op, sq_mul_b_op;
  logic [47:0] prod, sq_prod;

  // default configuration: A into pre-adder, pre-adder times B
  preadd_mult_front i_preadd_mult_front (
    .clk(clk), .rst_a(rst_a), .rst_b(rst_b), .rst_d(rst_d), .rst_ad(rst_ad),
    .rst_m(rst_m), .rst_p(rst_p), .ce_a1(ce_a1), .ce_a2(ce_a2), .ce_b1(ce_b1),
    .ce_b2(ce_b2), .ce_d(ce_d), .ce_ad(ce_ad), .ce_m(ce_m), .ce_p(ce_p),
    .mode(mode), .a_in(a_in), .b_in(b_in), .d_in(d_in),
    .mul_a_op(mul_a_op), .mul_b_op(mul_b_op), .prod(prod)
  );

  // squaring configuration: B into pre-adder, registered pre-adder on both ports
  preadd_mult_front #(.PRE_FROM_B(1'b1), .MB_FROM_PRE(1'b1), .AD_REG(1'b1)) i_square (
    .clk(clk), .rst_a(rst_a), .rst_b(rst_b), .rst_d(rst_d), .rst_ad(rst_ad),
    .rst_m(rst_m), .rst_p(rst_p), .ce_a1(ce_a1), .ce_a2(ce_a2), .ce_b1(ce_b1),
    .ce_b2(ce_b2), .ce_d(ce_d), .ce_ad(ce_ad), .ce_m(ce_m), .ce_p(ce_p),
    .mode(mode), .a_in(a_in), .b_in(b_in), .d_in(d_in),
    .mul_a_op(sq_mul_a_op), .mul_b_op(sq_mul_b_op), .prod(sq_prod)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic longint sx(longint v, int w);
    longint m;
    m = (longint'(1) <<< w) - 1;
    v = v & m;
    if (((v >>> (w - 1)) & 1) != 0) v = v - (longint'(1) <<< w);
    return v;
  endfunction

  function automatic longint pre_ref(longint dv, longint ov, logic [4:0] md);
    longint dt, ot;
    dt = md[2] ? dv : 0;
    ot = md[1] ? 0 : ov;
    return sx(md[3] ? (dt - ot) : (dt + ot), 27);
  endfunction

  function automatic longint exp_main();
    return sx(pre_ref(sx(d_in, 27), sx(a_in, 27), mode) * sx(b_in, 18), 48);
  endfunction

  function automatic longint exp_square();
    longint ad;
    ad = pre_ref(sx(d_in, 27), sx(b_in, 18), mode);
    return sx(ad * sx(ad, 18), 48);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    longint e_old, e_new;
    {rst_a, rst_b, rst_d, rst_ad, rst_m, rst_p} = 6'h3F;
    {ce_a1, ce_a2, ce_b1, ce_b2, ce_d, ce_ad, ce_m, ce_p} = 8'hFF;
    mode = 5'b10101;
    a_in = 30'h0123_4567; b_in = 18'h1_2345; d_in = 27'h0ABC_DEF;
    settle(4);
    // R1: reset beats enables
    check("R1 prod after reset", sx(prod, 48), 0);
    check("R1 mul_a_op after reset", sx(mul_a_op, 27), 0);
    check("R1 mul_b_op after reset", sx(mul_b_op, 18), 0);
    check("R1 square prod after reset", sx(sq_prod, 48), 0);
    {rst_a, rst_b, rst_d, rst_ad, rst_m, rst_p} = 6'h00;

    // R4 R5 R6 R7: every mode word with several operand patterns
    for (int m = 0; m < 32; m++) begin
      for (int s = 0; s < 4; s++) begin
        mode = 5'(m);
        case (s)
          0, 1: begin a_in = 30'($urandom); b_in = 18'($urandom); d_in = 27'($urandom); end
          2:    begin a_in = 30'h3C00_0000; b_in = 18'h2_0000; d_in = 27'h3FF_FFFF; end
          default: begin a_in = 30'h3800_0005; b_in = 18'h3_FFFD; d_in = 27'h000_0007; end
        endcase
        settle(6);
        check("R4 R7 product", sx(prod, 48), exp_main());
        check("R5 R6 mul_a_op", sx(mul_a_op, 27), pre_ref(sx(d_in, 27), sx(a_in, 27), mode));
        check("R6 mul_b_op", sx(mul_b_op, 18), sx(b_in, 18));
        check("R5 R6 square prod", sx(sq_prod, 48), exp_square());
        check("R6 square mul_b_op", sx(sq_mul_b_op, 18),
              sx(pre_ref(sx(d_in, 27), sx(b_in, 18), mode), 18));
      end
    end

    // R6: true square when the pre-adder result fits 18 bits
    mode = 5'b10101; d_in = 27'd300; b_in = 18'h3_FF00; // 300 + (-256) = 44
    settle(6);
    check("R6 square of 44", sx(sq_prod, 48), 1936);

    // R8: three-edge latency from a_in to prod
    mode = 5'b10101; a_in = 30'd5; b_in = 18'd7; d_in = 27'd0;
    settle(6);
    e_old = exp_main();
    a_in = 30'd11;
    e_new = exp_main();
    settle(2);
    check("R8 prod not yet updated after two edges", sx(prod, 48), e_old);
    settle(1);
    check("R8 prod updated on third edge", sx(prod, 48), e_new);

    // R2 R3: A tap select with the second register frozen
    mode = 5'b10100; a_in = 30'd9; b_in = 18'd3; d_in = 27'd1;
    settle(6);
    e_old = exp_main();
    check("R3 A second tap steady", sx(prod, 48), e_old);
    ce_a2 = 1'b0; a_in = 30'd20;
    settle(5);
    check("R2 R3 A second tap frozen", sx(prod, 48), e_old);
    mode[0] = 1'b1;
    settle(3);
    check("R3 A first tap", sx(prod, 48), exp_main());
    ce_a2 = 1'b1;

    // R2 R3: B tap select with the second register frozen
    mode = 5'b00101; a_in = 30'd4; b_in = 18'd6; d_in = 27'd2;
    settle(6);
    e_old = exp_main();
    ce_b2 = 1'b0; b_in = 18'h3_FFF0;
    settle(5);
    check("R2 R3 B second tap frozen", sx(prod, 48), e_old);
    mode[4] = 1'b1;
    settle(3);
    check("R3 B first tap", sx(prod, 48), exp_main());
    ce_b2 = 1'b1;

    // R9: output enable low holds prod
    mode = 5'b10101; a_in = 30'd100; b_in = 18'd100; d_in = 27'd1;
    settle(6);
    e_old = exp_main();
    ce_p = 1'b0; a_in = 30'd50;
    settle(5);
    check("R9 prod held with ce_p low", sx(prod, 48), e_old);
    ce_p = 1'b1;
    settle(3);
    check("R9 prod resumes with ce_p high", sx(prod, 48), exp_main());

    // R1: output reset wins while ce_p is high
    rst_p = 1'b1;
    settle(1);
    check("R1 rst_p clears prod", sx(prod, 48), 0);
    rst_p = 1'b0;
    settle(1);
    check("R1 prod returns after rst_p", sx(prod, 48), exp_main());

    // R10: pre-adder register enable in the squaring instance
    mode = 5'b10101; b_in = 18'd3; d_in = 27'd10;
    settle(6);
    e_old = exp_square();
    check("R10 square steady", sx(sq_prod, 48), 169);
    ce_ad = 1'b0; d_in = 27'd20;
    settle(6);
    check("R10 AD held with ce_ad low", sx(sq_prod, 48), e_old);
    ce_ad = 1'b1;
    settle(6);
    check("R10 AD loads with ce_ad high", sx(sq_prod, 48), 529);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule